// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This unit performs a byte-wise permute of a SIMD vector through a lookup table. The table is one to four 128-bit entries taken from a 32-entry vector register file. Each byte of an index vector is read as an unsigned number and picks one byte of that table. The picked bytes form the result, which is written back to a destination register.

A lane whose index falls past the end of the table gets one of two values, set per operation. In the zeroing variant it gets 0x00. In the merging variant it keeps the byte already held in that lane of the destination. Operands are either 64 bits wide (8 lanes) or 128 bits wide (16 lanes).

The unit drives the register file through a single read port with same-cycle read data and one write port. A small sequencer makes one read per cycle: first the index register, then each table register in turn, then the old destination (merging variant only). The next cycle it writes the result back. The cycle count depends only on the table length and the variant, never on data, so the timing reveals nothing about operand values.

Top module: `vtbl_lookup`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer returns to idle. From the next cycle on, `busy`, `done` and `rfWrEn` are 0. A reset during an operation aborts it, and the register file is not written.
- R2: After an accepted start, `rfRdAddr` steps through these values, one per cycle:
  - the index register number;
  - the table register numbers `baseReg`+0 through `baseReg`+`tblLen`, each taken modulo 32 (so 31 wraps to 0);
  - `dstReg`, in the merging variant only.
- R3: Table byte t (0 to 63) is byte t mod 16 of the table register at position t div 16, where position 0 is at `baseReg`. Byte b of any 128-bit vector is bits [8b+7:8b].
- R4: A lane's index is the unsigned value of its index byte. It is in range when it is less than 16 × (`tblLen` + 1), and an in-range index yields the table byte it names.
- R5: With `opMerge`=0, a lane whose index is out of range is written as 0x00.
- R6: With `opMerge`=1, a lane whose index is out of range is written with the byte held in the same lane of the destination register before the operation.
- R7: With `wide`=1, all 16 lanes are looked up. With `wide`=0, only lanes 0 to 7 are looked up, and bits [127:64] of the written result are zero.
- R8: `done` and `rfWrEn` are high together for exactly one cycle, with `rfWrAddr` = `dstReg`. This happens 2 + `tblLen` + `opMerge` cycles after the edge that accepts the start, whatever the data. No other register is written.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation keeps its fields, its timing and its destination.
- R10: `busy` is high from the cycle after an accepted start through the write-back cycle, and it is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted when not busy |
| baseReg | input | 5 | Number of the first table register |
| idxReg | input | 5 | Number of the index register |
| dstReg | input | 5 | Number of the destination register |
| opMerge | input | 1 | 0: out-of-range lanes are zeroed; 1: out-of-range lanes keep the destination byte |
| wide | input | 1 | 0: 64-bit operand (8 lanes); 1: 128-bit operand (16 lanes) |
| tblLen | input | 2 | Number of table registers minus one |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse in the write-back cycle |
| rfRdAddr | output | 5 | Register file read address |
| rfRdData | input | 128 | Register file read data, valid in the same cycle |
| rfWrEn | output | 1 | Register file write enable |
| rfWrAddr | output | 5 | Register file write address |
| rfWrData | output | 128 | Register file write data |

## Verification
The bench uses the package defaults: a 5-bit register number, 128-bit vectors with byte lanes, and up to four table registers. These give a 64-byte table and 32 registers, so index bytes can be placed exactly on the boundaries 16, 32, 48 and 64 and at 0xFF. The base register can be placed at 30 or 31 so that the table wraps to register 0. Both variants run at both widths, and each case is compared against a model built from the register file contents before the operation. The same setup also reaches a start pulse during a busy operation and a reset in the middle of a read sequence.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  parameter int REG_ADDR_W   = 5;
  parameter int VEC_W        = 128;
  parameter int BYTE_W       = 8;
  parameter int MAX_TBL_REGS = 4;

  localparam int LANES      = VEC_W / BYTE_W;
  localparam int LANE_SH    = $clog2(LANES);
  localparam int LEN_W      = $clog2(MAX_TBL_REGS);
  localparam int TBL_BYTES  = MAX_TBL_REGS * LANES;
  localparam int TBL_SEL_W  = $clog2(TBL_BYTES);
  localparam int LIMIT_W    = TBL_SEL_W + 1;

  typedef struct packed {
    logic             opMerge;
    logic             wide;
    logic [LEN_W-1:0] tblLen;
  } opCfg_t;

  typedef struct packed {
    logic             capIdx;
    logic             capTbl;
    logic [LEN_W-1:0] tblSlot;
    logic             capDst;
    logic             emit;
  } dpStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDX,
    ST_TBL,
    ST_DST,
    ST_WB
  } seqState_t;
endpackage

// File: rtl/vtbl_ctrl.sv
module vtbl_ctrl
  import vtbl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [REG_ADDR_W-1:0] baseReg,
  input  logic [REG_ADDR_W-1:0] idxReg,
  input  logic [REG_ADDR_W-1:0] dstReg,
  input  logic                  opMerge,
  input  logic                  wide,
  input  logic [LEN_W-1:0]      tblLen,
  output logic                  busy,
  output logic                  done,
  output logic [REG_ADDR_W-1:0] rdAddr,
  output logic                  wrEn,
  output logic [REG_ADDR_W-1:0] wrAddr,
  output opCfg_t                cfg,
  output dpStrb_t               strb
);
  seqState_t             state;
  opCfg_t                cfgQ;
  logic [REG_ADDR_W-1:0] baseQ;
  logic [REG_ADDR_W-1:0] idxQ;
  logic [REG_ADDR_W-1:0] dstQ;
  logic [LEN_W-1:0]      slotCnt;
  logic                  lastSlot;

  assign lastSlot = (slotCnt == cfgQ.tblLen);

  // Sequencer: state and slot counter are reset, operand fields are not
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_IDX;
            slotCnt <= '0;
          end
        end
        ST_IDX: state <= ST_TBL;
        ST_TBL: begin
          if (lastSlot) begin
            state <= cfgQ.opMerge ? ST_DST : ST_WB;
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
        ST_DST:  state <= ST_WB;
        ST_WB:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_IDLE && start) begin
      cfgQ.opMerge <= opMerge;
      cfgQ.wide    <= wide;
      cfgQ.tblLen  <= tblLen;
      baseQ        <= baseReg;
      idxQ         <= idxReg;
      dstQ         <= dstReg;
    end
  end

  // Read address: register numbers wrap because the adder is REG_ADDR_W wide
  always_comb begin
    unique case (state)
      ST_IDX:  rdAddr = idxQ;
      ST_TBL:  rdAddr = baseQ + REG_ADDR_W'(slotCnt);
      ST_DST:  rdAddr = dstQ;
      default: rdAddr = '0;
    endcase
  end

  always_comb begin
    strb.capIdx  = (state == ST_IDX);
    strb.capTbl  = (state == ST_TBL);
    strb.tblSlot = slotCnt;
    strb.capDst  = (state == ST_DST);
    strb.emit    = (state == ST_WB);
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_WB);
  assign wrEn   = (state == ST_WB);
  assign wrAddr = dstQ;
  assign cfg    = cfgQ;
endmodule

// File: rtl/vtbl_lane.sv
module vtbl_lane
  import vtbl_pkg::*;
(
  input  logic [BYTE_W-1:0]                 idxByte,
  input  logic [TBL_BYTES-1:0][BYTE_W-1:0]  tblBytes,
  input  logic [LIMIT_W-1:0]                limit,
  input  logic [BYTE_W-1:0]                 fallback,
  input  logic                              laneOn,
  output logic [BYTE_W-1:0]                 outByte
);
  localparam int CMP_W = (BYTE_W > LIMIT_W) ? BYTE_W + 1 : LIMIT_W + 1;

  logic              inRange;
  logic [BYTE_W-1:0] picked;

  assign inRange = CMP_W'(idxByte) < CMP_W'(limit);
  assign picked  = tblBytes[idxByte[TBL_SEL_W-1:0]];

  always_comb begin
    if (!laneOn)      outByte = '0;
    else if (inRange) outByte = picked;
    else              outByte = fallback;
  end
endmodule

// File: rtl/vtbl_dp.sv
module vtbl_dp
  import vtbl_pkg::*;
(
  input  logic             clk,
  input  dpStrb_t          strb,
  input  opCfg_t           cfg,
  input  logic [VEC_W-1:0] rdData,
  output logic [VEC_W-1:0] wrData
);
  logic [VEC_W-1:0]                        idxVec;
  logic [VEC_W-1:0]                        oldDst;
  logic [MAX_TBL_REGS-1:0][VEC_W-1:0]      tblMem;
  logic [TBL_BYTES-1:0][BYTE_W-1:0]        tblBytes;
  logic [LEN_W:0]                          regCnt;
  logic [LIMIT_W-1:0]                      limit;

  always_ff @(posedge clk) begin
    if (strb.capIdx) idxVec <= rdData;
    if (strb.capTbl) tblMem[strb.tblSlot] <= rdData;
    if (strb.capDst) oldDst <= rdData;
  end

  // Slot 0 holds the lowest 16 bytes; the packed layout gives byte t at slot t/16
  assign tblBytes = tblMem;
  assign regCnt   = {1'b0, cfg.tblLen} + 1'b1;
  assign limit    = LIMIT_W'(regCnt) << LANE_SH;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit LOW_HALF = (i < LANES / 2);
    logic [BYTE_W-1:0] fallback;
    assign fallback = cfg.opMerge ? oldDst[i*BYTE_W +: BYTE_W] : '0;

    vtbl_lane u_lane (
      .idxByte  (idxVec[i*BYTE_W +: BYTE_W]),
      .tblBytes (tblBytes),
      .limit    (limit),
      .fallback (fallback),
      .laneOn   (cfg.wide || LOW_HALF),
      .outByte  (wrData[i*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/vtbl_lookup.sv
module vtbl_lookup
  import vtbl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [REG_ADDR_W-1:0] baseReg,
  input  logic [REG_ADDR_W-1:0] idxReg,
  input  logic [REG_ADDR_W-1:0] dstReg,
  input  logic                  opMerge,
  input  logic                  wide,
  input  logic [LEN_W-1:0]      tblLen,
  output logic                  busy,
  output logic                  done,
  output logic [REG_ADDR_W-1:0] rfRdAddr,
  input  logic [VEC_W-1:0]      rfRdData,
  output logic                  rfWrEn,
  output logic [REG_ADDR_W-1:0] rfWrAddr,
  output logic [VEC_W-1:0]      rfWrData
);
  opCfg_t  cfg;
  dpStrb_t strb;

  vtbl_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .baseReg (baseReg),
    .idxReg  (idxReg),
    .dstReg  (dstReg),
    .opMerge (opMerge),
    .wide    (wide),
    .tblLen  (tblLen),
    .busy    (busy),
    .done    (done),
    .rdAddr  (rfRdAddr),
    .wrEn    (rfWrEn),
    .wrAddr  (rfWrAddr),
    .cfg     (cfg),
    .strb    (strb)
  );

  vtbl_dp u_dp (
    .clk    (clk),
    .strb   (strb),
    .cfg    (cfg),
    .rdData (rfRdData),
    .wrData (rfWrData)
  );
endmodule

// File: rtl/vtbl_lookup_chk.sv
module vtbl_lookup_chk
  import vtbl_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic                  wide,
  input logic                  opMerge,
  input logic [LEN_W-1:0]      tblLen,
  input logic [REG_ADDR_W-1:0] dstReg,
  input logic                  rfWrEn,
  input logic [REG_ADDR_W-1:0] rfWrAddr,
  input logic [VEC_W-1:0]      rfWrData
);
  logic                  wideL;
  logic                  mergeL;
  logic [LEN_W-1:0]      lenL;
  logic [REG_ADDR_W-1:0] dstL;
  logic [LEN_W+2:0]      cycCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wideL  <= 1'b1;
      mergeL <= 1'b0;
      lenL   <= '0;
      dstL   <= '0;
      cycCnt <= '0;
    end else if (start && !busy) begin
      wideL  <= wide;
      mergeL <= opMerge;
      lenL   <= tblLen;
      dstL   <= dstReg;
      cycCnt <= '0;
    end else if (busy && !done) begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  p_rst_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !rfWrEn && !done));

  p_narrow_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rfWrEn && !wideL) |-> (rfWrData[VEC_W-1:VEC_W/2] == '0));

  p_fixed_latency_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycCnt == (LEN_W+3)'(lenL) + (LEN_W+3)'(mergeL) + (LEN_W+3)'(2)));

  p_done_write_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (rfWrEn && rfWrAddr == dstL));

  p_write_only_done_r8: assert property (@(posedge clk) disable iff (rst)
    rfWrEn |-> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_after_start_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_busy_ends_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  p_busy_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

bind vtbl_lookup vtbl_lookup_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .wide     (wide),
  .opMerge  (opMerge),
  .tblLen   (tblLen),
  .dstReg   (dstReg),
  .rfWrEn   (rfWrEn),
  .rfWrAddr (rfWrAddr),
  .rfWrData (rfWrData)
);

// File: tb/sim_vtbl_lookup.sv
`timescale 1ns/1ps
module sim_vtbl_lookup;
  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [4:0]   baseReg, idxReg, dstReg;
  logic         opMerge, wide;
  logic [1:0]   tblLen;
  logic         busy, done;
  logic [4:0]   rfRdAddr;
  logic [127:0] rfRdData;
  logic         rfWrEn;
  logic [4:0]   rfWrAddr;
  logic [127:0] rfWrData;

  logic [127:0] rf [32];
  logic [127:0] snap [32];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vtbl_lookup u0 (
    .clk(clk), .rst(rst), .start(start), .baseReg(baseReg), .idxReg(idxReg),
    .dstReg(dstReg), .opMerge(opMerge), .wide(wide), .tblLen(tblLen),
    .busy(busy), .done(done), .rfRdAddr(rfRdAddr), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData)
  );

  assign rfRdData = rf[rfRdAddr];
  always @(posedge clk) if (rfWrEn) rf[rfWrAddr] <= rfWrData;

  typedef struct packed {
    logic [4:0] base;
    logic [4:0] idx;
    logic [4:0] dst;
    logic       merge;
    logic       wide;
    logic [1:0] len;
    logic [3:0] lat;
  } vec_t;

  // lat = cycles from the accepting edge to the write-back cycle: 2 + len + merge
  localparam vec_t VECS [6] = '{
    '{5'd10, 5'd5, 5'd20, 1'b0, 1'b1, 2'd0, 4'd2},
    '{5'd10, 5'd6, 5'd21, 1'b1, 1'b1, 2'd1, 4'd4},
    '{5'd30, 5'd6, 5'd22, 1'b1, 1'b1, 2'd3, 4'd6},
    '{5'd31, 5'd5, 5'd23, 1'b0, 1'b0, 2'd2, 4'd4},
    '{5'd2,  5'd6, 5'd24, 1'b1, 1'b0, 2'd3, 4'd6},
    '{5'd12, 5'd5, 5'd12, 1'b1, 1'b1, 2'd0, 4'd3}
  };

  // Byte 0 is the least significant byte; values sit on the table boundaries
  localparam logic [127:0] IDX6 = {8'h3E, 8'h80, 8'h35, 8'h25, 8'h15, 8'h05, 8'hFF, 8'h40,
                                   8'h3F, 8'h30, 8'h2F, 8'h20, 8'h1F, 8'h10, 8'h0F, 8'h00};

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic initRf();
    for (int r = 0; r < 32; r++)
      for (int b = 0; b < 16; b++)
        rf[r][8*b +: 8] = 8'(r * 37 + b * 11 + 5);
    for (int b = 0; b < 16; b++) rf[5][8*b +: 8] = 8'(b * 4 + 1);
    rf[6] = IDX6;
  endtask

  function automatic logic [127:0] refModel(input vec_t v);
    logic [127:0] res = '0;
    int lanes = v.wide ? 16 : 8;
    for (int i = 0; i < lanes; i++) begin
      int ix = int'(rf[v.idx][8*i +: 8]);
      if (ix < 16 * (int'(v.len) + 1))
        res[8*i +: 8] = rf[5'(int'(v.base) + ix / 16)][8*(ix % 16) +: 8];
      else if (v.merge)
        res[8*i +: 8] = rf[v.dst][8*i +: 8];
    end
    return res;
  endfunction

  function automatic logic [4:0] seqAddr(input vec_t v, input int k);
    if (k == 0) return v.idx;
    if (k <= int'(v.len) + 1) return 5'(int'(v.base) + k - 1);
    return v.dst;
  endfunction

  task automatic runOp(input vec_t v, input bit glitch, input string tag);
    logic [127:0] exp;
    int k = 0;
    int badSeq = 0;
    bit otherOk = 1;
    exp = refModel(v);
    for (int r = 0; r < 32; r++) snap[r] = rf[r];
    @(negedge clk);
    start = 1'b1; baseReg = v.base; idxReg = v.idx; dstReg = v.dst;
    opMerge = v.merge; wide = v.wide; tblLen = v.len;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {"R10 busy after start ", tag}, 128'(busy), 128'(1));
    while (!done && k < 40) begin
      if (rfRdAddr != seqAddr(v, k)) badSeq++;
      if (glitch) begin
        start = (k == 1);
        dstReg = 5'd25; baseReg = 5'd0; tblLen = 2'd3; opMerge = ~v.merge; wide = ~v.wide;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(k == int'(v.lat), {"R8 latency ", tag}, 128'(k), 128'(v.lat));
    check(badSeq == 0, {"R2 read order ", tag}, 128'(badSeq), 128'(0));
    check(rfWrEn && rfWrAddr == v.dst, {"R8 write addr ", tag}, 128'(rfWrAddr), 128'(v.dst));
    @(negedge clk);
    check(!busy && !done, {"R10 idle after write ", tag}, 128'({busy, done}), 128'(0));
    check(rf[v.dst] == exp, {"R3 R4 R5 R6 R7 result ", tag}, rf[v.dst], exp);
    for (int r = 0; r < 32; r++)
      if (r != int'(v.dst) && rf[r] != snap[r]) otherOk = 0;
    check(otherOk, {"R8 R9 other regs untouched ", tag}, 128'(otherOk), 128'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; baseReg = '0; idxReg = '0; dstReg = '0;
    opMerge = 1'b0; wide = 1'b1; tblLen = '0;
    initRf();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(!busy && !done && !rfWrEn, "R1 reset state", 128'({busy, done, rfWrEn}), 128'(0));

    // Vector table walk
    for (int n = 0; n < 6; n++) begin
      initRf();
      runOp(VECS[n], 1'b0, $sformatf("vec%0d", n));
    end

    // R9: start during busy is ignored
    initRf();
    runOp(VECS[1], 1'b1, "busy start");
    check(rf[25] == snap[25], "R9 ignored destination unchanged", rf[25], snap[25]);

    // R1: reset in the middle of an operation
    begin
      bit sawWr = 0;
      initRf();
      for (int r = 0; r < 32; r++) snap[r] = rf[r];
      @(negedge clk);
      start = 1'b1; baseReg = 5'd3; idxReg = 5'd6; dstReg = 5'd26;
      opMerge = 1'b1; wide = 1'b1; tblLen = 2'd3;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!busy && !done, "R1 abort to idle", 128'({busy, done}), 128'(0));
      for (int c = 0; c < 10; c++) begin
        if (rfWrEn || done) sawWr = 1;
        @(negedge clk);
      end
      check(!sawWr && rf[26] == snap[26], "R1 no write after abort", rf[26], snap[26]);
    end

    // Unit works again after the abort
    initRf();
    runOp(VECS[2], 1'b0, "after abort");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule